// File: doc/BRIEF.md
# Global Timer with Auto-Reload Comparator

This block is a free-running 64-bit up-counter that a host reaches through a small 32-bit register bus. The counter advances by one on every clock while it is switched on. Software can read it as two 32-bit words. Software can also write it, but only while it is stopped. A 64-bit compare register sits beside the counter. When compare is switched on and the counter is at or beyond the compare value, the block raises a sticky event flag. The flag drives an interrupt line when interrupts are enabled.

In periodic mode, every compare event adds a programmable 32-bit increment to the compare value. This gives an event every increment ticks without further software action. The event flag is cleared by writing a one to it. A fresh compare event in the same cycle takes precedence over that clear.

The bus has no handshake. A write takes effect at the clock edge on which the write strobe is high. Read data follows the address combinationally.

Top module: `gtimer_top`

## Requirements
- R1: While control bit 0 (run) is 1, the 64-bit counter increases by exactly one per clock. While run is 0, the counter holds its value.
- R2: When the low counter word wraps from 0xFFFFFFFF to 0, the high word increases by one at that same clock edge. A read of the high word, then the low word, then the high word again therefore gives a consistent value.
- R3: While run is 0, writes to byte offsets 0x00 and 0x04 load counter bits 31:0 and 63:32. While run is 1, such writes are ignored and counting continues.
- R4: While control bit 1 (compare enable) is 1, the event flag (status bit 0) becomes 1 one clock after any cycle in which counter >= compare, with the comparison taken over all 64 bits. While compare enable is 0, no counter or compare value and no compare-register write sets the flag.
- R5: While control bit 3 (periodic) is 1, every compare event adds the 32-bit increment register at offset 0x18 to the 64-bit compare value, with carry into the high word. Without periodic mode the compare value stays unchanged.
- R6: Writing 1 to status bit 0 at offset 0x0C clears the flag. Writing 0 there has no effect. If a compare event occurs in the same cycle as the clearing write, the flag stays 1.
- R7: irq_o is 1 exactly when the event flag is 1 and control bit 2 (interrupt enable) is 1. The flag is set regardless of control bit 2.
- R8: The register map is 0x00 counter low, 0x04 counter high, 0x08 control, 0x0C status, 0x10 compare low, 0x14 compare high and 0x18 increment. Control bits 31:4 and status bits 31:1 read as 0 and ignore writes.
- R9: After reset, every register reads 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | ADDR_W | Byte address of the register accessed |
| bus_we_i | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata_i | input | HALF_W | Write data |
| bus_rdata_o | output | HALF_W | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The assertions assume that the write strobe is a clean one-cycle level, never X. They also assume that the address is stable whenever the strobe is high. The bench drives every write as a single strobe cycle a fixed time after an edge, and then drops it.

The reload assertion leaves out cycles in which the compare register is being written, because the write wins in those cycles. The sweeps only program compare and increment values while compare is disabled.

Counter, flag and compare expectations are derived from the number of edges for which run stayed set, and that number is fixed by the order of the bus writes.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;

    // Byte offsets of the register file
    localparam int OFS_CNT_LO = 'h00;
    localparam int OFS_CNT_HI = 'h04;
    localparam int OFS_CTRL   = 'h08;
    localparam int OFS_STAT   = 'h0C;
    localparam int OFS_CMP_LO = 'h10;
    localparam int OFS_CMP_HI = 'h14;
    localparam int OFS_INC    = 'h18;

    localparam int CTRL_BITS = 4;

    // Packed so that run sits at bit 0 and periodic at bit 3
    typedef struct packed {
        logic periodic;
        logic irq_en;
        logic cmp_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/gtimer_counter.sv
module gtimer_counter #(
    parameter  int HALF_W = 32,
    localparam int CNT_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [HALF_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cnt_o
);

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } cnt_t;

    cnt_t              s_d, s_q;
    logic              lo_carry;
    logic [HALF_W-1:0] lo_inc;

    always_comb begin
        s_d = s_q;
        {lo_carry, lo_inc} = {1'b0, s_q.lo} + (HALF_W+1)'(1);
        if (run_i) begin
            // carry enters the high word at the same edge the low word wraps
            s_d.lo = lo_inc;
            s_d.hi = s_q.hi + HALF_W'(lo_carry);
        end else begin
            if (wr_lo_i) s_d.lo = wdata_i;
            if (wr_hi_i) s_d.hi = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = {s_q.hi, s_q.lo};

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> cnt_o == $past(cnt_o) + CNT_W'(1));

    assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_o));

    assert_carry_same_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && (&cnt_o[HALF_W-1:0])) |=>
            (cnt_o[HALF_W-1:0] == '0) &&
            (cnt_o[CNT_W-1:HALF_W] == $past(cnt_o[CNT_W-1:HALF_W]) + HALF_W'(1)));

    assert_load_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && wr_lo_i) |=> cnt_o[HALF_W-1:0] == $past(wdata_i));

endmodule

// File: rtl/gtimer_cmp.sv
module gtimer_cmp #(
    parameter  int HALF_W = 32,
    localparam int CNT_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              cmp_en_i,
    input  logic              periodic_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic              wr_inc_i,
    input  logic [HALF_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cmp_o,
    output logic [HALF_W-1:0] inc_o,
    output logic              hit_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  cmp;
        logic [HALF_W-1:0] inc;
    } cmp_state_t;

    cmp_state_t s_d, s_q;

    // greater-or-equal match, so a passed-over target still fires
    assign hit_o = cmp_en_i && (cnt_i >= s_q.cmp);

    always_comb begin
        s_d = s_q;
        if (hit_o && periodic_i) s_d.cmp = s_q.cmp + CNT_W'(s_q.inc);
        // a bus write to the compare value takes precedence over the reload
        if (wr_lo_i)  s_d.cmp[HALF_W-1:0]     = wdata_i;
        if (wr_hi_i)  s_d.cmp[CNT_W-1:HALF_W] = wdata_i;
        if (wr_inc_i) s_d.inc                 = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmp_o = s_q.cmp;
    assign inc_o = s_q.inc;

    assert_reload_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && periodic_i && !wr_lo_i && !wr_hi_i) |=>
            cmp_o == $past(cmp_o) + CNT_W'($past(inc_o)));

    assert_oneshot_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic_i && !wr_lo_i && !wr_hi_i) |=> $stable(cmp_o));

endmodule

// File: rtl/gtimer_top.sv
module gtimer_top
    import gtimer_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [HALF_W-1:0] bus_wdata_i,
    output logic [HALF_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    localparam int CNT_W = 2 * HALF_W;

    typedef struct packed {
        ctrl_t ctrl;
        logic  flag;
    } top_state_t;

    top_state_t       s_d, s_q;
    logic             wr_cnt_lo, wr_cnt_hi, wr_ctrl, wr_stat;
    logic             wr_cmp_lo, wr_cmp_hi, wr_inc;
    logic             hit;
    logic [CNT_W-1:0] cnt, cmp;
    logic [HALF_W-1:0] inc;

    // write decode
    assign wr_cnt_lo = bus_we_i && (bus_addr_i == ADDR_W'(OFS_CNT_LO));
    assign wr_cnt_hi = bus_we_i && (bus_addr_i == ADDR_W'(OFS_CNT_HI));
    assign wr_ctrl   = bus_we_i && (bus_addr_i == ADDR_W'(OFS_CTRL));
    assign wr_stat   = bus_we_i && (bus_addr_i == ADDR_W'(OFS_STAT));
    assign wr_cmp_lo = bus_we_i && (bus_addr_i == ADDR_W'(OFS_CMP_LO));
    assign wr_cmp_hi = bus_we_i && (bus_addr_i == ADDR_W'(OFS_CMP_HI));
    assign wr_inc    = bus_we_i && (bus_addr_i == ADDR_W'(OFS_INC));

    gtimer_counter #(.HALF_W(HALF_W)) counter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (s_q.ctrl.run),
        .wr_lo_i (wr_cnt_lo),
        .wr_hi_i (wr_cnt_hi),
        .wdata_i (bus_wdata_i),
        .cnt_o   (cnt)
    );

    gtimer_cmp #(.HALF_W(HALF_W)) cmp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (cnt),
        .cmp_en_i   (s_q.ctrl.cmp_en),
        .periodic_i (s_q.ctrl.periodic),
        .wr_lo_i    (wr_cmp_lo),
        .wr_hi_i    (wr_cmp_hi),
        .wr_inc_i   (wr_inc),
        .wdata_i    (bus_wdata_i),
        .cmp_o      (cmp),
        .inc_o      (inc),
        .hit_o      (hit)
    );

    always_comb begin
        s_d = s_q;
        if (wr_ctrl) s_d.ctrl = ctrl_t'(bus_wdata_i[CTRL_BITS-1:0]);
        // a new event outranks a simultaneous write-one-to-clear
        if (hit)                          s_d.flag = 1'b1;
        else if (wr_stat && bus_wdata_i[0]) s_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        case (int'(bus_addr_i))
            OFS_CNT_LO: bus_rdata_o = cnt[HALF_W-1:0];
            OFS_CNT_HI: bus_rdata_o = cnt[CNT_W-1:HALF_W];
            OFS_CTRL:   bus_rdata_o = HALF_W'(s_q.ctrl);
            OFS_STAT:   bus_rdata_o = HALF_W'(s_q.flag);
            OFS_CMP_LO: bus_rdata_o = cmp[HALF_W-1:0];
            OFS_CMP_HI: bus_rdata_o = cmp[CNT_W-1:HALF_W];
            OFS_INC:    bus_rdata_o = inc;
            default:    bus_rdata_o = '0;
        endcase
    end

    assign irq_o = s_q.flag & s_q.ctrl.irq_en;

    assert_ge_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.cmp_en && (cnt >= cmp)) |=> s_q.flag);

    assert_flag_needs_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flag) |-> $past(s_q.ctrl.cmp_en));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(s_q.ctrl.cmp_en && (cnt >= cmp)) && wr_stat && bus_wdata_i[0]) |=> !s_q.flag);

    assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> s_q.ctrl.irq_en);

endmodule

// File: tb/gtimer_top_tb.sv
`timescale 1ns/1ps
module gtimer_top_tb_top;

    localparam int HW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [HW-1:0] wdata = '0;
    logic [HW-1:0] rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gtimer_top #(.HALF_W(HW), .ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called 1 ns after an edge; consumes exactly one edge
    task automatic wr(input int a, input logic [31:0] d);
        addr = AW'(a); wdata = d; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = AW'(a); #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // run for exactly k counting edges, then stop everything
    task automatic run_for(input logic [31:0] ctrl, input int k);
        wr('h08, ctrl);
        idle(k - 1);
        wr('h08, 0);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] v, v2;
        logic [63:0] e64;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9 reset state, R8 map
        for (int a = 0; a <= 'h18; a += 4) begin
            rd(a, v);
            chk("R9 reset read", v, 0);
        end
        chk("R9 reset irq", irq, 0);

        // R8 reserved bits
        wr('h08, 32'hFFFF_FFF0);
        rd('h08, v); chk("R8 ctrl reserved", v, 0);
        wr('h0C, 32'hFFFF_FFFE);
        rd('h0C, v); chk("R8 stat reserved", v, 0);

        // R3 load while stopped
        wr('h00, 32'hA5A5_0001);
        wr('h04, 32'h0000_00C3);
        rd('h00, v); chk("R3 load lo", v, 32'hA5A5_0001);
        rd('h04, v); chk("R3 load hi", v, 32'hC3);

        // R1 step count sweep and hold
        for (int k = 1; k <= 10; k++) begin
            wr('h00, 32'h100); wr('h04, 0);
            run_for(1, k);
            rd('h00, v); chk("R1 count", v, 32'h100 + k);
            idle(3);
            rd('h00, v); chk("R1 hold", v, 32'h100 + k);
        end

        // R2 carry into high word
        for (int k = 1; k <= 3; k++) begin
            wr('h00, 32'hFFFF_FFFE); wr('h04, 7);
            run_for(1, k);
            e64 = {32'd7, 32'hFFFF_FFFE} + 64'(k);
            rd('h04, v); rd('h00, v2);
            chk("R2 carry", {v, v2}, e64);
        end
        wr('h00, 32'hFFFF_FFFF); wr('h04, 32'hFFFF_FFFF);
        run_for(1, 1);
        rd('h04, v); rd('h00, v2);
        chk("R2 full wrap", {v, v2}, 0);

        // R3 writes ignored while running
        wr('h00, 0); wr('h04, 0);
        wr('h08, 1);
        wr('h00, 32'h1234);
        wr('h08, 0);
        rd('h00, v); chk("R3 ignored while run", v, 2);

        // R4 greater-or-equal, one-shot sweep
        for (int c = 0; c <= 5; c++) begin
            for (int k = 1; k <= 7; k++) begin
                wr('h0C, 1);
                wr('h00, 0); wr('h04, 0);
                wr('h10, c); wr('h14, 0);
                run_for(3, k);
                rd('h0C, v); chk("R4 flag ge", v, (k - 1 >= c) ? 1 : 0);
                rd('h10, v); chk("R5 oneshot cmp kept", v, c);
            end
        end

        // R4 compare writes with compare disabled
        wr('h0C, 1);
        wr('h00, 100);
        wr('h10, 5); wr('h14, 0);
        rd('h0C, v); chk("R4 no flag while disabled", v, 0);
        wr('h08, 2);
        rd('h0C, v); chk("R4 flag one cycle later", v, 0);
        idle(1);
        rd('h0C, v); chk("R4 flag after enable", v, 1);

        // R6 clear semantics
        wr('h0C, 1);
        rd('h0C, v); chk("R6 event wins over clear", v, 1);
        wr('h08, 0);
        wr('h0C, 0);
        rd('h0C, v); chk("R6 write zero no effect", v, 1);
        wr('h0C, 1);
        rd('h0C, v); chk("R6 w1c clears", v, 0);

        // R7 interrupt gating
        wr('h08, 4);
        chk("R7 irq no flag", irq, 0);
        wr('h08, 2); idle(1);
        chk("R7 irq flag without enable", irq, 0);
        wr('h08, 6);
        chk("R7 irq asserted", irq, 1);
        wr('h08, 4);
        chk("R7 irq held by flag", irq, 1);
        wr('h0C, 1);
        chk("R7 irq after clear", irq, 0);
        wr('h08, 0);

        // R5 periodic sweep
        for (int inc = 1; inc <= 4; inc++) begin
            for (int k = 1; k <= 12; k++) begin
                wr('h0C, 1);
                wr('h00, 0); wr('h04, 0);
                wr('h10, inc); wr('h14, 0);
                wr('h18, inc);
                run_for(32'hB, k);
                rd('h10, v); chk("R5 periodic cmp", v, inc * (1 + (k - 1) / inc));
                rd('h0C, v); chk("R5 periodic flag", v, (k - 1 >= inc) ? 1 : 0);
                rd('h00, v); chk("R1 periodic count", v, k);
            end
        end
        rd('h18, v); chk("R8 inc readback", v, 4);

        // R5 reload carries into compare high word
        wr('h0C, 1);
        wr('h00, 32'hFFFF_FFF0); wr('h04, 0);
        wr('h10, 32'hFFFF_FFF8); wr('h14, 0);
        wr('h18, 32'h10);
        run_for(32'hB, 20);
        rd('h14, v); rd('h10, v2);
        chk("R5 reload carry", {v, v2}, 64'h1_0000_0008);

        summary();
    end

endmodule